// File: doc/BRIEF.md
# Nonvolatile Store and Recall Controller for a Quad Code Bank

This block keeps four 8-bit channel codes in working registers and shadows each one with a nonvolatile entry. In RTL the nonvolatile entries are a register array that reset does not clear. A write into an entry takes effect only after a programming delay, which is set as a clock-cycle count.

A serial front end, which is outside this block, decodes each frame. It passes the block a one-cycle pulse when the opcode and channel address are known. It passes a second one-cycle pulse when the eighth data bit of a write frame has arrived. It also passes the raw active-low chip select.

The block has four jobs:
- It guards programming with an arming latch. A nonvolatile entry is only written by a two-frame sequence: an arming frame, then a full write frame, finished by chip select going high.
- It holds its ready output low for the programming time and for the reload that follows reset. While ready is low, all host traffic is ignored.
- It recalls a single entry into its channel on command.
- It applies a mute input that forces every channel's output code to the low-reference code.

Top module: `nvstore_ctrl`

## Requirements
- R1: While `mute_i` is high, every channel field of `chan_code_o` reads code 0x00. When `mute_i` falls, the fields show the working-register codes again, unchanged by the mute period. Mute acts combinationally.
- R2: A write frame uses opcode 2'b01. Its data pulse loads the addressed working register, visible one cycle later. If the arming latch is clear, no programming starts: `rdy_o` stays high and the entry keeps its old value.
- R3: An arming frame uses opcode 2'b00 and sets the arming latch. Raising chip select after it, with no write frame in between, starts no programming.
- R4: Programming starts when all three hold: the latch is set, the current frame has delivered a complete write, and chip select rises. `rdy_o` then goes low one cycle after the first clock that samples chip select high, and stays low for exactly PROG_CYCLES cycles. After that the addressed entry holds the written code.
- R5: The arming latch clears when programming starts. A later armed-free write frame followed by a chip-select rise does not program.
- R6: If chip select rises before the data pulse of a write frame, no programming starts and the arming latch stays set.
- R7: While `rdy_o` is low, command pulses, data pulses and chip-select edges change no working register and no entry.
- R8: A recall frame uses opcode 2'b11. It copies the addressed nonvolatile entry into that channel's working register, visible one cycle after the command pulse.
- R9: During reset `rdy_o` is low. After reset is released, channels 0 to 3 are reloaded from their entries one per clock. `rdy_o` rises after the fourth clock. The entries keep their programmed values through reset.
- R10: A read frame uses opcode 2'b10 and changes no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; starts the reload sequence |
| cs_n_i | input | 1 | Active-low chip select from the host |
| cmd_valid_i | input | 1 | One-cycle pulse: opcode and address are decoded |
| cmd_op_i | input | 2 | Opcode: 00 arm, 01 write, 10 read, 11 recall |
| cmd_addr_i | input | 2 | Channel address |
| wdata_valid_i | input | 1 | One-cycle pulse: eight write data bits have arrived |
| wdata_i | input | 8 | Write data byte |
| mute_i | input | 1 | Active-high mute |
| rdy_o | output | 1 | High when idle, low while reloading or programming |
| chan_code_o | output | 32 | Effective codes; channel i in bits [8i+7:8i] |

## Verification
Register updates caused by write, recall and reload pulses are due one clock after the edge that samples the pulse. The mute effect appears in the same cycle, with no clock involved. `rdy_o` falls one clock after the edge that sees chip select high, and it rises exactly PROG_CYCLES clocks later.

The bench drives inputs at the falling edge. A behavioural reference model advances at every rising edge, and the bench compares every output 1 ns after that edge. Directed checks sample at falling edges that follow the edge which made the result due. The busy window is measured by counting low cycles of `rdy_o`.

// File: rtl/nvstore_pkg.sv
// Shared types for the nonvolatile store controller.
// Assumes the frame decoder presents opcodes in this 2-bit encoding.
package nvstore_pkg;
    typedef enum logic [1:0] {
        OP_ARM    = 2'b00,
        OP_WRITE  = 2'b01,
        OP_READ   = 2'b10,
        OP_RECALL = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_RELOAD = 2'b00,
        ST_IDLE   = 2'b01,
        ST_PROG   = 2'b10
    } seq_state_e;
endpackage

// File: rtl/nvstore_seq.sv
// Sequencer: power-on reload walk over all channels, then idle, then a
// programming wait of PROG_CYCLES clocks whenever a start pulse arrives.
// Assumes prog_start_i only pulses while idle_o is high.
module nvstore_seq
    import nvstore_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int PROG_CYCLES = 825_000,
    localparam int IDX_W      = $clog2(NUM_CH),
    localparam int CNT_W      = $clog2(PROG_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_start_i,
    output logic             idle_o,
    output logic             reload_en_o,
    output logic [IDX_W-1:0] reload_idx_o,
    output logic             commit_o
);
    seq_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;

    // Next-state and counter update for reload, idle and programming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RELOAD;
            idx_q   <= '0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_RELOAD: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == IDX_W'(NUM_CH - 1)) state_q <= ST_IDLE;
                end
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (prog_start_i) state_q <= ST_PROG;
                end
                ST_PROG: begin
                    if (cnt_q == CNT_W'(PROG_CYCLES - 1)) state_q <= ST_IDLE;
                    else cnt_q <= cnt_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Status decode for the datapath.
    always_comb begin
        idle_o       = (state_q == ST_IDLE);
        reload_en_o  = (state_q == ST_RELOAD);
        reload_idx_o = idx_q;
        commit_o     = (state_q == ST_PROG) && (cnt_q == CNT_W'(PROG_CYCLES - 1));
    end

    // R4: the programming counter never passes its limit.
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_PROG |-> cnt_q < CNT_W'(PROG_CYCLES));

    // R9: reload walks channels in ascending order.
    p_reload_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reload_en_o && reload_idx_o != '0 |-> $past(reload_idx_o) == reload_idx_o - 1'b1);
endmodule

// File: rtl/nvstore_cmd.sv
// Command tracker: arming latch, write-frame tracking and chip-select edge
// detection. It issues register writes, recalls and programming starts.
// Assumes cmd_valid_i and wdata_valid_i are single-cycle pulses inside a
// frame (cs_n_i low) and never coincide.
module nvstore_cmd
    import nvstore_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle_i,
    input  logic              cs_n_i,
    input  logic              cmd_valid_i,
    input  logic [1:0]        cmd_op_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic              wdata_valid_i,
    input  logic [CODE_W-1:0] wdata_i,
    output logic              dwr_en_o,
    output logic [ADDR_W-1:0] dwr_addr_o,
    output logic [CODE_W-1:0] dwr_data_o,
    output logic              recall_en_o,
    output logic [ADDR_W-1:0] recall_addr_o,
    output logic              prog_start_o,
    output logic [ADDR_W-1:0] prog_addr_o,
    output logic [CODE_W-1:0] prog_data_o
);
    logic              cs_q, arm_q, wact_q, pend_q;
    logic [ADDR_W-1:0] waddr_q;
    logic [CODE_W-1:0] pdata_q;
    logic              cmd_hit, data_hit, cs_rise;
    op_e               op;

    // Decode of accepted pulses and the programming trigger.
    always_comb begin
        op            = op_e'(cmd_op_i);
        cmd_hit       = idle_i && cmd_valid_i;
        data_hit      = idle_i && wdata_valid_i && wact_q;
        cs_rise       = cs_n_i && !cs_q;
        prog_start_o  = idle_i && cs_rise && pend_q;
        recall_en_o   = cmd_hit && (op == OP_RECALL);
        recall_addr_o = cmd_addr_i;
        dwr_en_o      = data_hit || prog_start_o;
        dwr_addr_o    = waddr_q;
        dwr_data_o    = prog_start_o ? pdata_q : wdata_i;
        prog_addr_o   = waddr_q;
        prog_data_o   = pdata_q;
    end

    // Chip-select history for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= 1'b1;
        else        cs_q <= cs_n_i;
    end

    // Arming latch: set by an arm frame, cleared when programming starts.
    always_ff @(posedge clk) begin
        if (!rst_n)                            arm_q <= 1'b0;
        else if (prog_start_o)                 arm_q <= 1'b0;
        else if (cmd_hit && op == OP_ARM)      arm_q <= 1'b1;
    end

    // Write-frame tracking, dropped whenever chip select is high.
    always_ff @(posedge clk) begin
        if (!rst_n)                            wact_q <= 1'b0;
        else if (cs_n_i)                       wact_q <= 1'b0;
        else if (cmd_hit && op == OP_WRITE)    wact_q <= 1'b1;
    end

    // Target channel of the current write frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                            waddr_q <= '0;
        else if (cmd_hit && op == OP_WRITE)    waddr_q <= cmd_addr_i;
    end

    // Pending programming request: a complete armed write in this frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                            pend_q <= 1'b0;
        else if (cs_n_i)                       pend_q <= 1'b0;
        else if (data_hit && arm_q)            pend_q <= 1'b1;
    end

    // Byte held for programming.
    always_ff @(posedge clk) begin
        if (!rst_n)        pdata_q <= '0;
        else if (data_hit) pdata_q <= wdata_i;
    end

    // R5: programming only ever starts with the latch armed.
    p_start_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start_o |-> arm_q);

    // R5: the latch is clear right after a start.
    p_arm_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start_o |=> !arm_q);
endmodule

// File: rtl/nvstore_bank.sv
// Storage: working registers (reset to zero, then reloaded) and the
// nonvolatile array, which reset never clears and only commits write.
// Assumes at most one of reload, register write and recall per cycle.
module nvstore_bank #(
    parameter int NUM_CH                     = 4,
    parameter int CODE_W                     = 8,
    parameter logic [NUM_CH*CODE_W-1:0] NV_INIT = '0,
    localparam int IDX_W                     = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reload_en_i,
    input  logic [IDX_W-1:0]         reload_idx_i,
    input  logic                     dwr_en_i,
    input  logic [IDX_W-1:0]         dwr_addr_i,
    input  logic [CODE_W-1:0]        dwr_data_i,
    input  logic                     recall_en_i,
    input  logic [IDX_W-1:0]         recall_addr_i,
    input  logic                     commit_i,
    input  logic [IDX_W-1:0]         prog_addr_i,
    input  logic [CODE_W-1:0]        prog_data_i,
    output logic [NUM_CH*CODE_W-1:0] dreg_o
);
    logic [NUM_CH-1:0][CODE_W-1:0] work_q;
    logic [NUM_CH-1:0][CODE_W-1:0] nv_q = NV_INIT;

    // Working registers: reload, then host write, then recall.
    always_ff @(posedge clk) begin
        if (!rst_n)           work_q <= '0;
        else if (reload_en_i) work_q[reload_idx_i] <= nv_q[reload_idx_i];
        else if (dwr_en_i)    work_q[dwr_addr_i] <= dwr_data_i;
        else if (recall_en_i) work_q[recall_addr_i] <= nv_q[recall_addr_i];
    end

    // Nonvolatile array: written only when a programming cycle ends.
    always_ff @(posedge clk) begin
        if (commit_i) nv_q[prog_addr_i] <= prog_data_i;
    end

    assign dreg_o = work_q;

    // R8: a lone recall lands the stored entry in its channel.
    p_recall_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        recall_en_i && !dwr_en_i && !reload_en_i
        |=> work_q[$past(recall_addr_i)] == $past(nv_q[recall_addr_i]));
endmodule

// File: rtl/nvstore_ctrl.sv
// Top: nonvolatile store and recall controller for NUM_CH channel codes.
// It ties together the command tracker, sequencer and storage, and
// applies mute to the effective output codes.
// Assumes frame decoding happens upstream; rdy_o is the internal
// open-drain-style status (low means busy).
module nvstore_ctrl #(
    parameter int NUM_CH                        = 4,
    parameter int CODE_W                        = 8,
    parameter int PROG_CYCLES                   = 825_000,
    parameter logic [CODE_W-1:0] LOW_CODE       = '0,
    parameter logic [NUM_CH*CODE_W-1:0] NV_INIT = 32'h8040_2010,
    parameter int ADDR_W                        = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n_i,
    input  logic                     cmd_valid_i,
    input  logic [1:0]               cmd_op_i,
    input  logic [ADDR_W-1:0]        cmd_addr_i,
    input  logic                     wdata_valid_i,
    input  logic [CODE_W-1:0]        wdata_i,
    input  logic                     mute_i,
    output logic                     rdy_o,
    output logic [NUM_CH*CODE_W-1:0] chan_code_o
);
    logic              idle, reload_en, commit, dwr_en, recall_en, prog_start;
    logic [ADDR_W-1:0] reload_idx, dwr_addr, recall_addr, prog_addr;
    logic [CODE_W-1:0] dwr_data, prog_data;
    logic [NUM_CH*CODE_W-1:0] dreg;

    nvstore_cmd #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .idle_i(idle), .cs_n_i(cs_n_i),
        .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_addr_i(cmd_addr_i),
        .wdata_valid_i(wdata_valid_i), .wdata_i(wdata_i),
        .dwr_en_o(dwr_en), .dwr_addr_o(dwr_addr), .dwr_data_o(dwr_data),
        .recall_en_o(recall_en), .recall_addr_o(recall_addr),
        .prog_start_o(prog_start), .prog_addr_o(prog_addr), .prog_data_o(prog_data)
    );

    nvstore_seq #(.NUM_CH(NUM_CH), .PROG_CYCLES(PROG_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .prog_start_i(prog_start), .idle_o(idle),
        .reload_en_o(reload_en), .reload_idx_o(reload_idx), .commit_o(commit)
    );

    nvstore_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .NV_INIT(NV_INIT)) u_bank (
        .clk(clk), .rst_n(rst_n), .reload_en_i(reload_en), .reload_idx_i(reload_idx),
        .dwr_en_i(dwr_en), .dwr_addr_i(dwr_addr), .dwr_data_i(dwr_data),
        .recall_en_i(recall_en), .recall_addr_i(recall_addr),
        .commit_i(commit), .prog_addr_i(prog_addr), .prog_data_i(prog_data),
        .dreg_o(dreg)
    );

    assign rdy_o = idle;

    // Mute selection per channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_mute
        assign chan_code_o[g*CODE_W +: CODE_W] = mute_i ? LOW_CODE : dreg[g*CODE_W +: CODE_W];
    end

    // R4: starting programming drops ready on the next cycle.
    p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> !rdy_o);

    // R4: the commit cycle is followed by ready.
    p_commit_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> rdy_o);

    // R7: while programming, the working registers are frozen.
    p_busy_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_o && !reload_en |=> $stable(dreg));
endmodule

// File: tb/nvstore_ctrl_tb_top.sv
// Bench for nvstore_ctrl: behavioural reference model compared every clock,
// plus directed checks per requirement.
module nvstore_ctrl_tb_top;
    localparam int P = 20;
    localparam logic [31:0] INIT = 32'h8040_2010;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [1:0] cmd_addr = 2'b00;
    logic       wdata_valid = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       mute = 1'b0;
    logic       rdy;
    logic [31:0] chan;

    int checks = 0;
    int fails = 0;
    bit cmp_on = 0;
    bit done = 0;

    nvstore_ctrl #(.PROG_CYCLES(P), .NV_INIT(INIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .cmd_valid_i(cmd_valid),
        .cmd_op_i(cmd_op), .cmd_addr_i(cmd_addr), .wdata_valid_i(wdata_valid),
        .wdata_i(wdata), .mute_i(mute), .rdy_o(rdy), .chan_code_o(chan)
    );

    always #2 clk = ~clk;

    // Reference model state.
    int         rl_left = 4, pg_left = 0, waddr_m = 0, paddr_m = 0;
    bit         arm_m = 0, wact_m = 0, pend_m = 0, csq_m = 1, rise_m = 0, start_m = 0;
    logic [7:0] pdata_m = 0;
    logic [7:0] dat_m [4];
    logic [7:0] nv_m [4];

    initial for (int i = 0; i < 4; i++) begin
        nv_m[i] = INIT[i*8 +: 8];
        dat_m[i] = 8'h00;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            rl_left = 4; pg_left = 0; arm_m = 0; wact_m = 0; pend_m = 0; csq_m = 1;
            for (int i = 0; i < 4; i++) dat_m[i] = 8'h00;
        end else begin
            rise_m = cs_n && !csq_m;
            if (rl_left > 0) begin
                dat_m[4 - rl_left] = nv_m[4 - rl_left];
                rl_left--;
            end else if (pg_left > 0) begin
                pg_left--;
                if (pg_left == 0) nv_m[paddr_m] = pdata_m;
            end else begin
                start_m = rise_m && pend_m;
                if (wdata_valid && wact_m) begin
                    dat_m[waddr_m] = wdata;
                    pdata_m = wdata;
                    if (arm_m) pend_m = 1;
                end
                if (cmd_valid) begin
                    case (cmd_op)
                        2'b00: arm_m = 1;
                        2'b01: begin wact_m = 1; waddr_m = cmd_addr; end
                        2'b11: dat_m[cmd_addr] = nv_m[cmd_addr];
                        default: ;
                    endcase
                end
                if (start_m) begin
                    pg_left = P; arm_m = 0; paddr_m = waddr_m; dat_m[waddr_m] = pdata_m;
                end
            end
            if (cs_n) begin wact_m = 0; pend_m = 0; end
            csq_m = cs_n;
        end
    end

    // Per-clock comparison, 1 ns after the rising edge.
    always @(posedge clk) begin
        #1;
        if (cmp_on && !done) begin
            checks++;
            if (rdy !== (rst_n && rl_left == 0 && pg_left == 0)) begin
                fails++;
                $display("FAIL model R4 rdy_o act=%0b exp=%0b", rdy, (rst_n && rl_left == 0 && pg_left == 0));
            end
            for (int i = 0; i < 4; i++) begin
                checks++;
                if (chan[i*8 +: 8] !== (mute ? 8'h00 : dat_m[i])) begin
                    fails++;
                    $display("FAIL model R1 ch%0d act=%h exp=%h", i, chan[i*8 +: 8], (mute ? 8'h00 : dat_m[i]));
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic [1:0] a);
        @(negedge clk); cmd_valid = 1; cmd_op = op; cmd_addr = a;
        @(negedge clk); cmd_valid = 0;
    endtask

    task automatic send_data(input logic [7:0] d);
        @(negedge clk); wdata_valid = 1; wdata = d;
        @(negedge clk); wdata_valid = 0;
    endtask

    task automatic cs_set(input logic v);
        @(negedge clk); cs_n = v;
    endtask

    function automatic logic [7:0] ch(input int i);
        return chan[i*8 +: 8];
    endfunction

    // Count the low cycles of rdy after chip select is raised.
    task automatic busy_len(output int n);
        n = 0;
        cs_set(1);
        @(negedge clk);
        while (!rdy && n < 10 * P) begin n++; @(negedge clk); end
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(4 * 100_000);
        fails++;
        $display("FAIL watchdog R4 act=%0d exp=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int n;
        cyc(2);
        cmp_on = 1;
        chk(rdy == 0, "R9 rdy in reset", rdy, 0);
        rst_n = 1;
        cyc(3);
        chk(rdy == 0, "R9 rdy mid reload", rdy, 0);
        cyc(1);
        chk(rdy == 1, "R9 rdy after reload", rdy, 1);
        chk(chan == INIT, "R9 reloaded codes", chan, INIT);

        // R1 mute
        @(negedge clk); mute = 1;
        @(negedge clk);
        chk(chan == 32'h0, "R1 muted", chan, 0);
        mute = 0;
        @(negedge clk);
        chk(chan == INIT, "R1 unmuted", chan, INIT);

        // R10 read
        cs_set(0); send_cmd(2'b10, 2'd1); cs_set(1); cyc(2);
        chk(chan == INIT && rdy, "R10 read no effect", chan, INIT);

        // R2 unarmed write
        cs_set(0); send_cmd(2'b01, 2'd2); send_data(8'hA5);
        chk(ch(2) == 8'hA5, "R2 write lands", ch(2), 8'hA5);
        cs_set(1); cyc(2);
        chk(rdy == 1, "R2 no programming", rdy, 1);
        cs_set(0); send_cmd(2'b11, 2'd2);
        chk(ch(2) == 8'h40, "R8 recall old entry R2", ch(2), 8'h40);
        cs_set(1);

        // R3 arm only
        cs_set(0); send_cmd(2'b00, 2'd0); cs_set(1); cyc(2);
        chk(rdy == 1, "R3 arm alone", rdy, 1);

        // R6 early chip select, then full write
        cs_set(0); send_cmd(2'b01, 2'd1); cs_set(1); cyc(2);
        chk(rdy == 1, "R6 early cs no program", rdy, 1);
        cs_set(0); send_cmd(2'b01, 2'd1); send_data(8'h3C);
        busy_len(n);
        chk(n == P, "R4 busy length R6 latch kept", n, P);
        cs_set(0); send_cmd(2'b11, 2'd1);
        chk(ch(1) == 8'h3C, "R4 entry programmed R8", ch(1), 8'h3C);
        cs_set(1);

        // R5 latch cleared
        cs_set(0); send_cmd(2'b01, 2'd1); send_data(8'h99); cs_set(1); cyc(2);
        chk(rdy == 1, "R5 no second program", rdy, 1);
        cs_set(0); send_cmd(2'b11, 2'd1);
        chk(ch(1) == 8'h3C, "R5 entry kept", ch(1), 8'h3C);
        cs_set(1);

        // R7 traffic while busy
        cs_set(0); send_cmd(2'b00, 2'd0); cs_set(1);
        cs_set(0); send_cmd(2'b01, 2'd3); send_data(8'h77); cs_set(1);
        @(negedge clk);
        chk(rdy == 0, "R7 busy started", rdy, 0);
        cs_set(0); send_cmd(2'b01, 2'd0); send_data(8'h11); send_cmd(2'b11, 2'd3); cs_set(1);
        n = 0;
        while (!rdy && n < 10 * P) begin n++; @(negedge clk); end
        chk(ch(0) == 8'h10, "R7 ch0 untouched", ch(0), 8'h10);
        chk(ch(3) == 8'h77, "R7 ch3 kept", ch(3), 8'h77);

        // R9 retention through reset
        @(negedge clk); rst_n = 0;
        cyc(2); rst_n = 1;
        cyc(4);
        chk(rdy == 1, "R9 ready again", rdy, 1);
        chk(chan == 32'h7740_3C10, "R9 retained entries", chan, 32'h7740_3C10);
        cyc(2);
        finish_run();
    end
endmodule